// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block is one hardware performance-monitoring counter. Every clock it is offered a few per-cycle event counts: a one-bit "processor running" indication, a count of instructions retired, and five per-line-state data-cache refill counts. It also sees the current privilege level. A 32-bit selector register picks one event and decides how it is qualified: by line-state mask, by privilege, by a threshold compare that may be inverted, and optionally by rising-edge detection. The qualified amount is added to a 48-bit wrapping counter.

When the counter wraps, the block can latch a sticky interrupt request and toggle an output pin. Software reaches the selector, the counter and the interrupt flag through a simple synchronous register port. Reads are combinational. Writes take effect at the next clock edge.

Register addresses: 0 is the selector, 1 is the counter, 2 is the status register (bit 0 is the interrupt flag), and 3 reads as zero.

Selector layout:

| Bits  | Field                          |
|-------|--------------------------------|
| 7:0   | event code                     |
| 15:8  | unit mask                      |
| 16    | count at user privilege (1..3) |
| 17    | count at kernel privilege (0)  |
| 18    | edge mode                      |
| 19    | pin toggle on wrap             |
| 20    | interrupt on wrap              |
| 21    | reserved, always zero          |
| 22    | enable                         |
| 23    | invert                         |
| 31:24 | threshold                      |

Top module: `perf_evt_ctr`

## Requirements
- R1: After synchronous reset, the selector, the counter and the interrupt flag read as zero, and both `ovf_irq` and `ovf_pin_o` are low.
- R2: A write to address 0 stores bits 31:0 into the selector from the next cycle on. Bit 21 always reads back as zero.
- R3: Event code 76h adds 1 in each cycle in which `cyc_running` is high. Code C0h adds `retired_cnt`. Any other code, apart from 42h, adds nothing.
- R4: Code 42h adds the sum of the refill lanes whose unit-mask bit is set. Lane k is `refill_cnt[4k+3:4k]` and is selected by selector bit 8+k. Lanes 4 down to 0 stand for the M, O, E, S and I states. A unit mask of zero adds nothing.
- R5: Counting happens at privilege 0 only when bit 17 is set, and at privilege 1, 2 or 3 only when bit 16 is set.
- R6: With bit 22 clear, the counter does not change.
- R7: With a threshold of zero, the selected count is added as is. With a nonzero threshold, 1 is added in each cycle where count >= threshold. With bit 23 set, 1 is added in each cycle where count < threshold.
- R8: In edge mode, 1 is added only when the qualified condition (count nonzero for threshold zero, otherwise the compare result, gated by enable and privilege) is true and was false in the previous cycle. The previous-cycle history is kept in every mode.
- R9: The counter is 48 bits and wraps to zero. A write to address 1 sets the counter in the next cycle and replaces any increment in that cycle.
- R10: A wrap with bit 20 set raises `ovf_irq`, which stays high until a selector write, or a status write with data bit 0 set, clears it. The clear wins over a wrap in the same cycle. A status write with bit 0 clear has no effect.
- R11: Each wrap with bit 19 set inverts `ovf_pin_o`. A counter write never toggles it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_running | input | 1 | Processor-running indication for this cycle |
| retired_cnt | input | 4 | Instructions retired this cycle |
| refill_cnt | input | 20 | Five 4-bit refill counts, lane 4 = M down to lane 0 = I |
| cpl | input | 2 | Current privilege level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 48 | Register write data |
| reg_rdata | output | 48 | Register read data for `reg_addr` |
| ovf_irq | output | 1 | Sticky wrap interrupt request |
| ovf_pin_o | output | 1 | Pin that toggles on each wrap |

## Verification
Each selector setting is driven with pseudo-random running, retired and refill patterns, so that raw accumulation, the threshold and inverted compares, and edge detection all give different totals from the same stimulus. Privilege is swept across all four levels with each enable combination. This shows whether the kernel and user bits are swapped or ignored. Refill masks with alternating lanes, and a mask of zero, show whether each lane maps to the right selector bit. Repeated counter loads just below the wrap point, some made while increments arrive, separate write-over-increment priority, single-wrap pin toggling, and the sticky flag's two clear paths.

// File: rtl/pec_pkg.sv
package pec_pkg;

    localparam int SEL_W   = 32;
    localparam int THR_W   = 8;
    localparam int N_STATE = 5;

    localparam logic [7:0] EV_RUN    = 8'h76;
    localparam logic [7:0] EV_RETIRE = 8'hC0;
    localparam logic [7:0] EV_REFILL = 8'h42;

    typedef struct packed {
        logic [THR_W-1:0] thresh;
        logic             inv;
        logic             en;
        logic             rsvd;
        logic             irq_on_wrap;
        logic             pin_on_wrap;
        logic             edge_md;
        logic             kern;
        logic             user;
        logic [7:0]       umask;
        logic [7:0]       code;
    } evsel_t;

    typedef enum logic [1:0] {
        RA_SEL  = 2'd0,
        RA_CTR  = 2'd1,
        RA_STAT = 2'd2,
        RA_NONE = 2'd3
    } regaddr_e;

    function automatic logic priv_pass(input logic kern, input logic user,
                                       input logic [1:0] cpl);
        return (cpl == 2'd0) ? kern : user;
    endfunction

    function automatic evsel_t scrub_sel(input logic [SEL_W-1:0] raw);
        evsel_t s;
        s      = evsel_t'(raw);
        s.rsvd = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/pec_event_sel.sv
module pec_event_sel
    import pec_pkg::*;
#(
    parameter int CW    = 4,
    parameter int NS    = N_STATE,
    parameter int SUM_W = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           code,
    input  logic [NS-1:0]        umask,
    input  logic                 kern,
    input  logic                 user,
    input  logic [1:0]           cpl,
    input  logic                 cyc_running,
    input  logic [CW-1:0]        retired_cnt,
    input  logic [NS*CW-1:0]     refill_cnt,
    output logic [SUM_W-1:0]     raw,
    output logic                 priv_ok
);

    logic [NS-1:0][SUM_W-1:0] lane;
    logic [SUM_W-1:0]         refill_sum;

    for (genvar g = 0; g < NS; g++) begin : g_lane
        assign lane[g] = umask[g] ? SUM_W'(refill_cnt[g*CW +: CW]) : '0;
    end

    always_comb begin
        refill_sum = '0;
        for (int i = 0; i < NS; i++) begin
            refill_sum = refill_sum + lane[i];
        end
    end

    always_comb begin
        case (code)
            EV_RUN:    raw = SUM_W'(cyc_running);
            EV_RETIRE: raw = SUM_W'(retired_cnt);
            EV_REFILL: raw = refill_sum;
            default:   raw = '0;
        endcase
    end

    assign priv_ok = priv_pass(kern, user, cpl);

    // R3
    unsupported_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (code != EV_RUN && code != EV_RETIRE && code != EV_REFILL) |-> (raw == '0));

    // R4
    empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (code == EV_REFILL && umask == '0) |-> (raw == '0));

endmodule

// File: rtl/pec_qualify.sv
module pec_qualify
    import pec_pkg::*;
#(
    parameter int SUM_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              inv,
    input  logic              edge_md,
    input  logic [THR_W-1:0]  thresh,
    input  logic [SUM_W-1:0]  raw,
    input  logic              priv_ok,
    output logic [SUM_W-1:0]  inc
);

    localparam int CMP_W = (SUM_W > THR_W) ? SUM_W : THR_W;

    logic             active;
    logic             cond;
    logic             hit;
    logic             prev_hit;
    logic [CMP_W-1:0] raw_x;
    logic [CMP_W-1:0] thr_x;

    assign raw_x = CMP_W'(raw);
    assign thr_x = CMP_W'(thresh);

    always_comb begin
        active = en && priv_ok;
        if (thresh == '0)   cond = (raw != '0);
        else if (inv)       cond = (raw_x < thr_x);
        else                cond = (raw_x >= thr_x);
        hit = active && cond;

        if (!active)             inc = '0;
        else if (edge_md)        inc = SUM_W'(hit && !prev_hit);
        else if (thresh == '0)   inc = raw;
        else                     inc = SUM_W'(cond);
    end

    always_ff @(posedge clk) begin
        if (rst) prev_hit <= 1'b0;
        else     prev_hit <= hit;
    end

    // R6
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> (inc == '0));

    // R5
    priv_block_chk: assert property (@(posedge clk) disable iff (rst)
        !priv_ok |-> (inc == '0));

    // R7
    thresh_unit_chk: assert property (@(posedge clk) disable iff (rst)
        (thresh != '0) |-> (inc <= SUM_W'(1)));

    // R8
    edge_no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_md && inc != '0) |=> (!$stable(thresh) || !$stable(inv) || !$stable(edge_md) || inc == '0));

endmodule

// File: rtl/pec_accum.sv
module pec_accum #(
    parameter int CTR_W = 48,
    parameter int SUM_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SUM_W-1:0]  inc,
    input  logic              ctr_we,
    input  logic [CTR_W-1:0]  ctr_wdata,
    input  logic              irq_en,
    input  logic              pin_en,
    input  logic              irq_clr,
    output logic [CTR_W-1:0]  ctr,
    output logic              irq,
    output logic              pin
);

    logic [CTR_W:0] sum;
    logic           wrap;

    assign sum  = {1'b0, ctr} + (CTR_W+1)'(inc);
    assign wrap = !ctr_we && sum[CTR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr <= '0;
            irq <= 1'b0;
            pin <= 1'b0;
        end else begin
            ctr <= ctr_we ? ctr_wdata : sum[CTR_W-1:0];
            if (irq_clr)               irq <= 1'b0;
            else if (wrap && irq_en)   irq <= 1'b1;
            if (wrap && pin_en)        pin <= ~pin;
        end
    end

    // R9
    ctr_load_chk: assert property (@(posedge clk) disable iff (rst)
        ctr_we |=> (ctr == $past(ctr_wdata)));

    // R10
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    // R10
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        irq_clr |=> !irq);

    // R11
    pin_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pin) |-> ($past(pin_en) && !$past(ctr_we) && ctr < $past(ctr)));

endmodule

// File: rtl/perf_evt_ctr.sv
module perf_evt_ctr
    import pec_pkg::*;
#(
    parameter int CTR_W = 48,
    parameter int CW    = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cyc_running,
    input  logic [CW-1:0]          retired_cnt,
    input  logic [N_STATE*CW-1:0]  refill_cnt,
    input  logic [1:0]             cpl,
    input  logic                   reg_we,
    input  logic [1:0]             reg_addr,
    input  logic [CTR_W-1:0]       reg_wdata,
    output logic [CTR_W-1:0]       reg_rdata,
    output logic                   ovf_irq,
    output logic                   ovf_pin_o
);

    localparam int SUM_W = CW + $clog2(N_STATE + 1);

    evsel_t           sel_q;
    evsel_t           sel_d;
    logic             sel_we;
    logic             ctr_we;
    logic             irq_clr;
    logic [SUM_W-1:0] raw;
    logic [SUM_W-1:0] inc;
    logic             priv_ok;
    logic [CTR_W-1:0] ctr;

    assign sel_d   = scrub_sel(reg_wdata[SEL_W-1:0]);
    assign sel_we  = reg_we && (reg_addr == RA_SEL);
    assign ctr_we  = reg_we && (reg_addr == RA_CTR);
    assign irq_clr = sel_we || (reg_we && (reg_addr == RA_STAT) && reg_wdata[0]);

    always_ff @(posedge clk) begin
        if (rst)         sel_q <= '0;
        else if (sel_we) sel_q <= sel_d;
    end

    pec_event_sel #(.CW(CW), .NS(N_STATE), .SUM_W(SUM_W)) u_sel (
        .clk         (clk),
        .rst         (rst),
        .code        (sel_q.code),
        .umask       (sel_q.umask[N_STATE-1:0]),
        .kern        (sel_q.kern),
        .user        (sel_q.user),
        .cpl         (cpl),
        .cyc_running (cyc_running),
        .retired_cnt (retired_cnt),
        .refill_cnt  (refill_cnt),
        .raw         (raw),
        .priv_ok     (priv_ok)
    );

    pec_qualify #(.SUM_W(SUM_W)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .en      (sel_q.en),
        .inv     (sel_q.inv),
        .edge_md (sel_q.edge_md),
        .thresh  (sel_q.thresh),
        .raw     (raw),
        .priv_ok (priv_ok),
        .inc     (inc)
    );

    pec_accum #(.CTR_W(CTR_W), .SUM_W(SUM_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .inc       (inc),
        .ctr_we    (ctr_we),
        .ctr_wdata (reg_wdata),
        .irq_en    (sel_q.irq_on_wrap),
        .pin_en    (sel_q.pin_on_wrap),
        .irq_clr   (irq_clr),
        .ctr       (ctr),
        .irq       (ovf_irq),
        .pin       (ovf_pin_o)
    );

    always_comb begin
        case (reg_addr)
            RA_SEL:  reg_rdata = CTR_W'(sel_q);
            RA_CTR:  reg_rdata = ctr;
            RA_STAT: reg_rdata = CTR_W'(ovf_irq);
            default: reg_rdata = '0;
        endcase
    end

    // R2
    sel_write_chk: assert property (@(posedge clk) disable iff (rst)
        sel_we |=> (sel_q.code == $past(reg_wdata[7:0]) && sel_q.umask == $past(reg_wdata[15:8])));

endmodule

// File: tb/sim_perf_evt_ctr.sv
`timescale 1ns/1ps
module sim_perf_evt_ctr;

    logic        clk = 1'b0;
    logic        rst;
    logic        cyc_running;
    logic [3:0]  retired_cnt;
    logic [19:0] refill_cnt;
    logic [1:0]  cpl;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [47:0] reg_wdata;
    logic [47:0] reg_rdata;
    logic        ovf_irq;
    logic        ovf_pin_o;

    always #2.5 clk = ~clk;

    perf_evt_ctr u0 (
        .clk(clk), .rst(rst), .cyc_running(cyc_running), .retired_cnt(retired_cnt),
        .refill_cnt(refill_cnt), .cpl(cpl), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_irq(ovf_irq), .ovf_pin_o(ovf_pin_o)
    );

    int          n_vec  = 0;
    int          n_miss = 0;
    string       cur_req = "R1";
    logic [31:0] lfsr = 32'h1357_9BDF;

    logic [31:0] m_sel  = '0;
    logic [47:0] m_ctr  = '0;
    logic        m_irq  = 1'b0;
    logic        m_pin  = 1'b0;
    logic        m_prev = 1'b0;

    localparam logic [47:0] MAXC = 48'hFFFF_FFFF_FFFF;
    localparam logic [31:0] B_USER = 32'h0001_0000, B_KERN = 32'h0002_0000,
                            B_EDGE = 32'h0004_0000, B_PIN  = 32'h0008_0000,
                            B_IRQ  = 32'h0010_0000, B_EN   = 32'h0040_0000,
                            B_INV  = 32'h0080_0000;

    function automatic logic [31:0] step_rnd(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic check(input string what, input logic [47:0] act, input logic [47:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // One clock: drive inputs, advance the model, compare after the edge.
    task automatic tick(input logic we, input logic [1:0] a, input logic [47:0] wd, input int cmode);
        int          raw;
        int          inc;
        int          thr;
        logic        act, cnd, hit, wrap, clr;
        logic [48:0] sum;
        lfsr = step_rnd(lfsr);
        cyc_running = lfsr[0];
        retired_cnt = lfsr[7:4];
        refill_cnt  = lfsr[31:12];
        cpl         = (cmode < 4) ? 2'(cmode) : lfsr[9:8];
        reg_we = we; reg_addr = a; reg_wdata = wd;

        raw = 0;
        case (m_sel[7:0])
            8'h76: raw = int'(cyc_running);
            8'hC0: raw = int'(retired_cnt);
            8'h42: for (int s = 0; s < 5; s++) if (m_sel[8+s]) raw += int'(refill_cnt[s*4 +: 4]);
            default: raw = 0;
        endcase
        act = m_sel[22] && ((cpl == 2'd0) ? m_sel[17] : m_sel[16]);
        thr = int'(m_sel[31:24]);
        if (thr == 0)        cnd = (raw != 0);
        else if (m_sel[23])  cnd = (raw < thr);
        else                 cnd = (raw >= thr);
        hit = act && cnd;
        if (!act)            inc = 0;
        else if (m_sel[18])  inc = (hit && !m_prev) ? 1 : 0;
        else if (thr == 0)   inc = raw;
        else                 inc = cnd ? 1 : 0;
        sum  = {1'b0, m_ctr} + 49'(inc);
        wrap = !(we && a == 2'd1) && sum[48];
        clr  = we && (a == 2'd0 || (a == 2'd2 && wd[0]));

        @(posedge clk);
        m_prev = hit;
        m_ctr  = (we && a == 2'd1) ? wd : sum[47:0];
        if (clr)                  m_irq = 1'b0;
        else if (wrap && m_sel[20]) m_irq = 1'b1;
        if (wrap && m_sel[19])    m_pin = ~m_pin;
        if (we && a == 2'd0)      m_sel = wd[31:0] & ~32'h0020_0000;

        @(negedge clk);
        case (a)
            2'd0:    check("selector", reg_rdata, {16'h0, m_sel});
            2'd1:    check("counter", reg_rdata, m_ctr);
            2'd2:    check("status", reg_rdata, {47'h0, m_irq});
            default: check("empty", reg_rdata, 48'h0);
        endcase
        check("irq", {47'h0, ovf_irq}, {47'h0, m_irq});
        check("pin", {47'h0, ovf_pin_o}, {47'h0, m_pin});
    endtask

    task automatic run(input int n, input int cmode);
        for (int i = 0; i < n; i++) tick(1'b0, 2'd1, 48'h0, cmode);
    endtask

    task automatic wsel(input logic [31:0] v);
        tick(1'b1, 2'd0, {16'h0, v}, 4);
    endtask

    task automatic wctr(input logic [47:0] v);
        tick(1'b1, 2'd1, v, 4);
    endtask

    initial begin
        #500000;
        n_miss++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        rst = 1'b1; cyc_running = 0; retired_cnt = 0; refill_cnt = 0; cpl = 0;
        reg_we = 0; reg_addr = 0; reg_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state through every readable address
        cur_req = "R1";
        tick(1'b0, 2'd0, 48'h0, 4);
        tick(1'b0, 2'd1, 48'h0, 4);
        tick(1'b0, 2'd2, 48'h0, 4);
        tick(1'b0, 2'd3, 48'h0, 4);

        // R2: selector store and reserved bit
        cur_req = "R2";
        wsel(32'hFFFF_FFFF);
        tick(1'b0, 2'd0, 48'h0, 4);
        wsel(32'h0020_0000);
        tick(1'b0, 2'd0, 48'h0, 4);

        // R3: running cycles, retired instructions, unsupported code
        cur_req = "R3";
        wsel(B_EN | B_USER | B_KERN | 32'h76);
        run(20, 4);
        wsel(B_EN | B_USER | B_KERN | 32'hC0);
        run(20, 4);
        wsel(B_EN | B_USER | B_KERN | 32'h55);
        run(10, 4);

        // R4: refill lanes by line state
        cur_req = "R4";
        wsel(B_EN | B_USER | B_KERN | 32'h1542);
        run(15, 4);
        wsel(B_EN | B_USER | B_KERN | 32'h0A42);
        run(15, 4);
        wsel(B_EN | B_USER | B_KERN | 32'h0042);
        run(8, 4);

        // R5: privilege filters over all levels
        cur_req = "R5";
        wsel(B_EN | B_KERN | 32'hC0);
        for (int c = 0; c < 4; c++) run(5, c);
        wsel(B_EN | B_USER | 32'hC0);
        for (int c = 0; c < 4; c++) run(5, c);
        wsel(B_EN | 32'hC0);
        run(10, 4);

        // R6: master enable clear
        cur_req = "R6";
        wsel(B_USER | B_KERN | 32'hC0);
        run(10, 4);

        // R7: threshold and inverted threshold
        cur_req = "R7";
        wsel(32'h0800_0000 | B_EN | B_USER | B_KERN | 32'hC0);
        run(25, 4);
        wsel(32'h0800_0000 | B_INV | B_EN | B_USER | B_KERN | 32'hC0);
        run(25, 4);
        wsel(32'h1E00_0000 | B_EN | B_USER | B_KERN | 32'h1F42);
        run(20, 4);

        // R8: edge detect on raw and thresholded conditions
        cur_req = "R8";
        wsel(B_EDGE | B_EN | B_USER | B_KERN | 32'h76);
        run(30, 4);
        wsel(32'h0600_0000 | B_EDGE | B_EN | B_USER | B_KERN | 32'hC0);
        run(30, 4);
        wsel(B_EDGE | B_EN | B_USER | 32'h76);
        run(30, 4);

        // R9: counter load overrides increment, and wraps
        cur_req = "R9";
        wsel(B_EN | B_USER | B_KERN | 32'hC0);
        run(3, 4);
        wctr(48'h0000_1234_5678);
        wctr(48'h0000_0000_0010);
        run(3, 4);
        wctr(MAXC - 48'd2);
        run(6, 4);

        // R10: sticky interrupt and both clear paths
        cur_req = "R10";
        wsel(B_IRQ | B_EN | B_USER | B_KERN | 32'h76);
        wctr(MAXC);
        run(40, 1);
        tick(1'b1, 2'd2, 48'h0, 4);
        run(3, 4);
        tick(1'b1, 2'd2, 48'h1, 4);
        run(3, 4);
        wctr(MAXC - 48'd1);
        run(12, 4);
        wsel(B_IRQ | B_EN | B_USER | B_KERN | 32'h76);
        run(5, 4);

        // R11: pin toggles once per wrap
        cur_req = "R11";
        wsel(B_PIN | B_IRQ | B_EN | B_USER | B_KERN | 32'hC0);
        for (int k = 0; k < 4; k++) begin
            wctr(MAXC - 48'd6);
            run(8, 4);
        end
        wctr(MAXC);
        wctr(48'h0);
        run(4, 4);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule